// File: doc/BRIEF.md
# Dual Mailbox Bypass Between Two Clock Domains

This block carries short control words between two ports that run on independent clocks, without queueing them in the bulk data FIFOs. It holds two mailboxes of `DW` bits each. Mailbox 1 is loaded from port A and read from port B. Mailbox 2 is loaded from port B and read from port A. Each mailbox has one pending flag. The writing side sets it and the reading side clears it. Each side sees its own view of the flag, registered in its own clock domain.

A mailbox accepts a word only while the writer sees it as vacant. A load attempt while mail is pending is dropped, and the stored word is kept. Reading a mailbox does not change its contents. The read only hands the slot back to the writer. The set and clear events cross between the domains as toggles through two-flop synchronizers, so an event is never lost and the clocks may be fully asynchronous or coincident.

The block also holds the port-A output selector, which returns either mailbox 2 or the FIFO output word, with a high-impedance state. It also holds the port-B rule that treats a size code of 2'b11 as a mailbox access.

Top module: `mbx_pair`

## Requirements
- R1: A rising `clk_a` edge with `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbx_sel`=1 and `mbx1_empty_a`=1 loads `a_din` into mailbox 1. The new word appears on `b_mbx_q` after that edge.
- R2: A rising `clk_b` edge with `b_cs_n`=0, `b_wr`=1, `b_en`=1, `b_siz`=2'b11 and `mbx2_empty_b`=1 loads `b_din` into mailbox 2.
- R3: An accepted load drives the writer-side flag (`mbx1_empty_a` or `mbx2_empty_b`) low after that edge. The reader-side flag (`mbx1_avail_b` or `mbx2_avail_a`) rises after the second following reader clock edge.
- R4: A load attempt while the writer-side flag is low is ignored, and the stored word stays unchanged.
- R5: A port-B edge with `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_siz`=2'b11 while `mbx1_avail_b`=1 drops `mbx1_avail_b` after that edge. `mbx1_empty_a` then returns high after the second following `clk_a` edge. A port-A edge with `a_cs_n`=0, `a_wr`=0, `a_en`=1, `a_mbx_sel`=1 while `mbx2_avail_a`=1 does the same for mailbox 2.
- R6: Reading a mailbox, or trying to read it while it is not available, leaves its contents unchanged. A read while not available also changes no flag.
- R7: While a reset is high, and after it, both writer-side flags are high, both reader-side flags are low and both mailboxes hold zero.
- R8: With `a_cs_n`=0 and `a_wr`=0, `a_dout` shows mailbox 2 when `a_mbx_sel`=1 and `fifo2_q` when `a_mbx_sel`=0, whatever the level of `a_en`. Otherwise `a_dout` is high-impedance.
- R9: `b_mbx_sel` is high exactly when `b_siz`=2'b11. Port-B reads or writes with any other size code leave both mailboxes and their flags untouched.
- R10: A port-A access with `a_en`=0, `a_cs_n`=1 or `a_mbx_sel`=0 does not load mailbox 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| rst_a | input | 1 | Synchronous active-high reset, port-A domain |
| a_cs_n | input | 1 | Port-A select, active low |
| a_wr | input | 1 | Port-A direction: 1 write, 0 read |
| a_en | input | 1 | Port-A transfer enable |
| a_mbx_sel | input | 1 | Port-A mailbox select (1 mailbox, 0 FIFO) |
| a_din | input | DW | Port-A write data |
| fifo2_q | input | DW | FIFO output word offered to port A |
| a_dout | output | DW | Port-A read data, high-impedance when not driving |
| mbx1_empty_a | output | 1 | Mailbox 1 vacant, port-A view |
| mbx2_avail_a | output | 1 | Mailbox 2 holds unread mail, port-A view |
| clk_b | input | 1 | Port-B clock |
| rst_b | input | 1 | Synchronous active-high reset, port-B domain |
| b_cs_n | input | 1 | Port-B select, active low |
| b_wr | input | 1 | Port-B direction: 1 write, 0 read |
| b_en | input | 1 | Port-B transfer enable |
| b_siz | input | 2 | Port-B size code, 2'b11 means mailbox |
| b_din | input | DW | Port-B write data |
| b_mbx_sel | output | 1 | Port-B access targets a mailbox |
| b_mbx_q | output | DW | Mailbox 1 contents for port B |
| mbx1_avail_b | output | 1 | Mailbox 1 holds unread mail, port-B view |
| mbx2_empty_b | output | 1 | Mailbox 2 vacant, port-B view |

## Verification
A wrong toggle or synchronizer state shows up as a flag pair that disagrees for longer than the two-edge crossing window. Either the reader sees mail that was never written, or the writer stays locked out after a read. With coincident clocks the exact edge on which each flag moves is known, so the bench compares every flag on every cycle and catches any mismatch on the first cycle it occurs. A corrupted data register, or a load the block should have refused, shows on `b_mbx_q` or on `a_dout` in the cycle right after the offending edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned SIZ_W = 2;
    localparam logic [SIZ_W-1:0] SIZ_MAILBOX = 2'b11;

    typedef struct packed {
        logic cs_n;
        logic wr;
        logic en;
    } strobe_t;

    function automatic logic fn_is_write(input strobe_t s);
        return !s.cs_n && s.wr && s.en;
    endfunction

    function automatic logic fn_is_read(input strobe_t s);
        return !s.cs_n && !s.wr && s.en;
    endfunction

    function automatic logic fn_drives(input strobe_t s);
        return !s.cs_n && !s.wr;
    endfunction

    function automatic logic fn_b_mailbox(input logic [SIZ_W-1:0] siz);
        return siz == SIZ_MAILBOX;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk_w,
    input  logic          rst_w,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          vacant_w,
    output logic [DW-1:0] mail_q,
    input  logic          clk_r,
    input  logic          rst_r,
    input  logic          rd_req,
    output logic          avail_r
);
    logic put_tog;
    logic take_tog;
    logic put_tog_r;
    logic take_tog_w;

    // writer domain: toggle marks a new word, data held while pending
    always_ff @(posedge clk_w) begin
        if (rst_w) begin
            put_tog <= 1'b0;
            mail_q  <= '0;
        end else if (wr_req && vacant_w) begin
            put_tog <= ~put_tog;
            mail_q  <= wr_data;
        end
    end

    assign vacant_w = (put_tog == take_tog_w);

    mbx_sync #(.STAGES(STAGES)) u_put_xing (
        .clk (clk_r),
        .rst (rst_r),
        .d   (put_tog),
        .q   (put_tog_r)
    );

    // reader domain: toggle hands the slot back
    assign avail_r = put_tog_r ^ take_tog;

    always_ff @(posedge clk_r) begin
        if (rst_r)                   take_tog <= 1'b0;
        else if (rd_req && avail_r)  take_tog <= ~take_tog;
    end

    mbx_sync #(.STAGES(STAGES)) u_take_xing (
        .clk (clk_w),
        .rst (rst_w),
        .d   (take_tog),
        .q   (take_tog_w)
    );
endmodule

// File: rtl/mbx_a_outmux.sv
module mbx_a_outmux #(
    parameter int unsigned DW = 36
) (
    input  mbx_pkg::strobe_t strb,
    input  logic             mbx_sel,
    input  logic [DW-1:0]    mail,
    input  logic [DW-1:0]    fifo,
    output logic             drive,
    output logic [DW-1:0]    word
);
    import mbx_pkg::*;

    always_comb begin
        drive = fn_drives(strb);
        word  = mbx_sel ? mail : fifo;
    end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic                      clk_a,
    input  logic                      rst_a,
    input  logic                      a_cs_n,
    input  logic                      a_wr,
    input  logic                      a_en,
    input  logic                      a_mbx_sel,
    input  logic [DW-1:0]             a_din,
    input  logic [DW-1:0]             fifo2_q,
    output logic [DW-1:0]             a_dout,
    output logic                      mbx1_empty_a,
    output logic                      mbx2_avail_a,
    input  logic                      clk_b,
    input  logic                      rst_b,
    input  logic                      b_cs_n,
    input  logic                      b_wr,
    input  logic                      b_en,
    input  logic [mbx_pkg::SIZ_W-1:0] b_siz,
    input  logic [DW-1:0]             b_din,
    output logic                      b_mbx_sel,
    output logic [DW-1:0]             b_mbx_q,
    output logic                      mbx1_avail_b,
    output logic                      mbx2_empty_b
);
    import mbx_pkg::*;

    strobe_t       a_strb;
    strobe_t       b_strb;
    logic          a_put;
    logic          a_take;
    logic          b_put;
    logic          b_take;
    logic [DW-1:0] mail2_q;
    logic          a_drive;
    logic [DW-1:0] a_word;

    always_comb begin
        a_strb    = '{cs_n: a_cs_n, wr: a_wr, en: a_en};
        b_strb    = '{cs_n: b_cs_n, wr: b_wr, en: b_en};
        b_mbx_sel = fn_b_mailbox(b_siz);
        a_put     = fn_is_write(a_strb) && a_mbx_sel;
        a_take    = fn_is_read(a_strb)  && a_mbx_sel;
        b_put     = fn_is_write(b_strb) && b_mbx_sel;
        b_take    = fn_is_read(b_strb)  && b_mbx_sel;
    end

    // mailbox 1: port A to port B
    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mbx1 (
        .clk_w    (clk_a),
        .rst_w    (rst_a),
        .wr_req   (a_put),
        .wr_data  (a_din),
        .vacant_w (mbx1_empty_a),
        .mail_q   (b_mbx_q),
        .clk_r    (clk_b),
        .rst_r    (rst_b),
        .rd_req   (b_take),
        .avail_r  (mbx1_avail_b)
    );

    // mailbox 2: port B to port A
    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mbx2 (
        .clk_w    (clk_b),
        .rst_w    (rst_b),
        .wr_req   (b_put),
        .wr_data  (b_din),
        .vacant_w (mbx2_empty_b),
        .mail_q   (mail2_q),
        .clk_r    (clk_a),
        .rst_r    (rst_a),
        .rd_req   (a_take),
        .avail_r  (mbx2_avail_a)
    );

    mbx_a_outmux #(.DW(DW)) u_amux (
        .strb    (a_strb),
        .mbx_sel (a_mbx_sel),
        .mail    (mail2_q),
        .fifo    (fifo2_q),
        .drive   (a_drive),
        .word    (a_word)
    );

    assign a_dout = a_drive ? a_word : {DW{1'bz}};
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk_a,
    input logic          rst_a,
    input logic          a_cs_n,
    input logic          a_wr,
    input logic          a_en,
    input logic          a_mbx_sel,
    input logic [DW-1:0] a_din,
    input logic [DW-1:0] a_dout,
    input logic          mbx1_empty_a,
    input logic          mbx2_avail_a,
    input logic          clk_b,
    input logic          rst_b,
    input logic          b_cs_n,
    input logic          b_wr,
    input logic          b_en,
    input logic [1:0]    b_siz,
    input logic [DW-1:0] b_din,
    input logic [DW-1:0] b_mbx_q,
    input logic          mbx1_avail_b,
    input logic          mbx2_empty_b,
    input logic [DW-1:0] mail2_q
);
    logic a_put, a_take, b_put, b_take;
    assign a_put  = !a_cs_n &&  a_wr && a_en && a_mbx_sel;
    assign a_take = !a_cs_n && !a_wr && a_en && a_mbx_sel;
    assign b_put  = !b_cs_n &&  b_wr && b_en && (b_siz == 2'b11);
    assign b_take = !b_cs_n && !b_wr && b_en && (b_siz == 2'b11);

    AST_M1_LOAD: assert property (@(posedge clk_a) disable iff (rst_a)
        a_put && mbx1_empty_a |=> b_mbx_q == $past(a_din));                 // R1
    AST_M2_LOAD: assert property (@(posedge clk_b) disable iff (rst_b)
        b_put && mbx2_empty_b |=> mail2_q == $past(b_din));                 // R2
    AST_M1_WR_FLAG: assert property (@(posedge clk_a) disable iff (rst_a)
        a_put && mbx1_empty_a |=> !mbx1_empty_a);                           // R3
    AST_M2_WR_FLAG: assert property (@(posedge clk_b) disable iff (rst_b)
        b_put && mbx2_empty_b |=> !mbx2_empty_b);                           // R3
    AST_M1_HOLD: assert property (@(posedge clk_a) disable iff (rst_a)
        !mbx1_empty_a |=> $stable(b_mbx_q));                                // R4
    AST_M2_HOLD: assert property (@(posedge clk_b) disable iff (rst_b)
        !mbx2_empty_b |=> $stable(mail2_q));                                // R4
    AST_M1_RD_CLR: assert property (@(posedge clk_b) disable iff (rst_b)
        b_take && mbx1_avail_b |=> !mbx1_avail_b);                          // R5
    AST_M2_RD_CLR: assert property (@(posedge clk_a) disable iff (rst_a)
        a_take && mbx2_avail_a |=> !mbx2_avail_a);                          // R5
    AST_RST_A: assert property (@(posedge clk_a)
        rst_a |=> mbx1_empty_a && !mbx2_avail_a);                           // R7
    AST_RST_B: assert property (@(posedge clk_b)
        rst_b |=> mbx2_empty_b && !mbx1_avail_b);                           // R7
    AST_A_MUX: assert property (@(posedge clk_a) disable iff (rst_a)
        !a_cs_n && !a_wr && a_mbx_sel |-> a_dout == mail2_q);               // R8
endmodule

bind mbx_pair mbx_pair_chk #(.DW(DW)) u_chk (
    .clk_a        (clk_a),
    .rst_a        (rst_a),
    .a_cs_n       (a_cs_n),
    .a_wr         (a_wr),
    .a_en         (a_en),
    .a_mbx_sel    (a_mbx_sel),
    .a_din        (a_din),
    .a_dout       (a_dout),
    .mbx1_empty_a (mbx1_empty_a),
    .mbx2_avail_a (mbx2_avail_a),
    .clk_b        (clk_b),
    .rst_b        (rst_b),
    .b_cs_n       (b_cs_n),
    .b_wr         (b_wr),
    .b_en         (b_en),
    .b_siz        (b_siz),
    .b_din        (b_din),
    .b_mbx_q      (b_mbx_q),
    .mbx1_avail_b (mbx1_avail_b),
    .mbx2_empty_b (mbx2_empty_b),
    .mail2_q      (mail2_q)
);

// File: tb/mbx_pair_tb.sv
`timescale 1ns/1ps
module mbx_pair_tb;
    localparam int DW = 36;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx_sel = 1'b0;
    logic [DW-1:0] a_din = '0, fifo2_q = '0;
    logic          b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0;
    logic [1:0]    b_siz = 2'b00;
    logic [DW-1:0] b_din = '0;
    wire  [DW-1:0] a_dout;
    logic          mbx1_empty_a, mbx2_avail_a, b_mbx_sel, mbx1_avail_b, mbx2_empty_b;
    logic [DW-1:0] b_mbx_q;

    mbx_pair #(.DW(DW)) u_dut (
        .clk_a(clk), .rst_a(rst), .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en),
        .a_mbx_sel(a_mbx_sel), .a_din(a_din), .fifo2_q(fifo2_q), .a_dout(a_dout),
        .mbx1_empty_a(mbx1_empty_a), .mbx2_avail_a(mbx2_avail_a),
        .clk_b(clk), .rst_b(rst), .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en),
        .b_siz(b_siz), .b_din(b_din), .b_mbx_sel(b_mbx_sel), .b_mbx_q(b_mbx_q),
        .mbx1_avail_b(mbx1_avail_b), .mbx2_empty_b(mbx2_empty_b)
    );

    int n_chk = 0, n_fail = 0, edge_no = 0;
    bit done = 1'b0;

    // behavioural model: busy seen by writer, mail seen by reader, event edges
    bit            m1_busy, m1_mail, m2_busy, m2_mail;
    int            m1_mail_at, m1_free_at, m2_mail_at, m2_free_at;
    logic [DW-1:0] m1_data, m2_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit w1, r1, w2, r2;
        edge_no++;
        if (rst) begin
            m1_busy = 0; m1_mail = 0; m2_busy = 0; m2_mail = 0;
            m1_mail_at = -1; m1_free_at = -1; m2_mail_at = -1; m2_free_at = -1;
            m1_data = '0; m2_data = '0;
            return;
        end
        w1 = !a_cs_n && a_wr && a_en && a_mbx_sel && !m1_busy;
        r1 = !b_cs_n && !b_wr && b_en && (b_siz == 2'b11) && m1_mail;
        w2 = !b_cs_n && b_wr && b_en && (b_siz == 2'b11) && !m2_busy;
        r2 = !a_cs_n && !a_wr && a_en && a_mbx_sel && m2_mail;
        if (m1_mail_at == edge_no) m1_mail = 1;
        if (m1_free_at == edge_no) m1_busy = 0;
        if (m2_mail_at == edge_no) m2_mail = 1;
        if (m2_free_at == edge_no) m2_busy = 0;
        if (w1) begin m1_busy = 1; m1_data = a_din; m1_mail_at = edge_no + 2; end
        if (r1) begin m1_mail = 0; m1_free_at = edge_no + 2; end
        if (w2) begin m2_busy = 1; m2_data = b_din; m2_mail_at = edge_no + 2; end
        if (r2) begin m2_mail = 0; m2_free_at = edge_no + 2; end
    endtask

    task automatic step(input string tag);
        logic [DW-1:0] exp_a;
        @(posedge clk);
        model_edge();
        #2;
        chk(mbx1_empty_a === !m1_busy, tag, "mbx1_empty_a", DW'(mbx1_empty_a), DW'(!m1_busy));
        chk(mbx1_avail_b === m1_mail,  tag, "mbx1_avail_b", DW'(mbx1_avail_b), DW'(m1_mail));
        chk(mbx2_empty_b === !m2_busy, tag, "mbx2_empty_b", DW'(mbx2_empty_b), DW'(!m2_busy));
        chk(mbx2_avail_a === m2_mail,  tag, "mbx2_avail_a", DW'(mbx2_avail_a), DW'(m2_mail));
        chk(b_mbx_q === m1_data, tag, "b_mbx_q", b_mbx_q, m1_data);
        if (!a_cs_n && !a_wr) exp_a = a_mbx_sel ? m2_data : fifo2_q;
        else                  exp_a = {DW{1'bz}};
        chk(a_dout === exp_a, (a_mbx_sel && !a_cs_n && !a_wr) ? tag : "R8", "a_dout", a_dout, exp_a);
        chk(b_mbx_sel === (b_siz == 2'b11), "R9", "b_mbx_sel", DW'(b_mbx_sel), DW'(b_siz == 2'b11));
    endtask

    task automatic a_idle(); a_cs_n = 1; a_wr = 0; a_en = 0; a_mbx_sel = 0; endtask
    task automatic b_idle(); b_cs_n = 1; b_wr = 0; b_en = 0; b_siz = 2'b00; endtask
    task automatic a_put(input logic [DW-1:0] d);
        a_cs_n = 0; a_wr = 1; a_en = 1; a_mbx_sel = 1; a_din = d;
    endtask
    task automatic b_put(input logic [DW-1:0] d);
        b_cs_n = 0; b_wr = 1; b_en = 1; b_siz = 2'b11; b_din = d;
    endtask

    initial begin
        #1;
        rst = 1;
        for (int i = 0; i < 3; i++) step("R7");
        rst = 0;
        step("R7"); step("R7");

        a_put(36'h1_2345_6789); step("R1");
        a_idle(); for (int i = 0; i < 3; i++) step("R3");
        a_put(36'hF_0F0F_0F0F); step("R4");
        a_idle(); step("R4"); step("R4");
        b_cs_n = 0; b_wr = 0; b_en = 1; b_siz = 2'b01; step("R9"); step("R9");
        b_siz = 2'b11; step("R5");
        b_idle(); for (int i = 0; i < 3; i++) step("R5");
        b_cs_n = 0; b_wr = 0; b_en = 1; b_siz = 2'b11; step("R6"); step("R6");
        b_idle();

        a_put(36'hA_AAAA_5555); a_en = 0; step("R10");
        a_put(36'hA_AAAA_5555); a_cs_n = 1; step("R10");
        a_put(36'hA_AAAA_5555); a_mbx_sel = 0; step("R10");
        a_idle(); step("R10");

        a_put(36'h0_0000_0001); step("R1");
        a_idle(); step("R3"); step("R3");
        b_cs_n = 0; b_wr = 0; b_en = 1; b_siz = 2'b11; step("R5");
        b_idle();
        for (int i = 0; i < 4; i++) begin a_put(36'h8_0000_0000 + 36'(i)); step("R4"); end
        a_idle(); step("R3"); step("R3");

        b_put(36'h5_5555_AAAA); b_siz = 2'b10; step("R9");
        b_put(36'h7_6543_210F); step("R2");
        b_idle(); fifo2_q = 36'hC_0FFE_E123;
        a_cs_n = 0; a_wr = 0; a_en = 1; a_mbx_sel = 0; step("R8"); step("R8");
        a_mbx_sel = 1; a_en = 0; step("R8");
        a_en = 1; step("R5");
        a_en = 0; for (int i = 0; i < 3; i++) step("R6");
        a_cs_n = 1; step("R8");
        a_cs_n = 0; a_wr = 1; step("R8");
        a_idle();

        a_put(36'h3_3333_3333); b_put(36'h4_4444_4444); step("R2");
        a_idle(); b_idle(); for (int i = 0; i < 3; i++) step("R3");
        a_cs_n = 0; a_wr = 0; a_en = 1; a_mbx_sel = 1;
        b_cs_n = 0; b_wr = 0; b_en = 1; b_siz = 2'b11; step("R5");
        a_idle(); b_idle(); for (int i = 0; i < 3; i++) step("R5");

        a_put(36'h9_9999_0000); step("R1");
        a_idle(); step("R3");
        rst = 1; step("R7"); step("R7");
        rst = 0; step("R7"); step("R7");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule